// File: doc/BRIEF.md
# Model-specific register access unit

This unit keeps two model-specific registers that a microcode or instruction sequencer reaches through register-index accesses: a 64-bit cycle counter that advances on every clock, and a test register whose single live bit turns off the level-1 caches. The sequencer presents a register index, a read or write strobe, the current privilege level and, for writes, the value split into an upper and a lower 32-bit half. Reads return the value in the same two halves on the cycle after the strobe.

A separate fast counter-read strobe returns the counter without an index. It is open to every privilege level unless the time-stamp-disable control is set, in which case only privilege level 0 may use it. Any denied or unknown access raises a one-cycle fault pulse and changes no register. Instruction decoding, exception delivery, the other registers of this kind and the caches themselves are outside the unit.

Top module: `msr_unit`

## Requirements
- R1: After reset the counter, the cache-inhibit bit, both read halves and the fault flag are all zero.
- R2: The counter rises by one on every clock edge that carries no successful counter write, and wraps from all ones to zero.
- R3: An index read of 0x10 at privilege 0 returns the counter value of the strobe cycle on the next cycle, bits 63:32 on `rd_hi` and bits 31:0 on `rd_lo`.
- R4: An index write of 0x10 at privilege 0 loads `{wr_hi, wr_lo}` in place of the increment: the counter equals the written value on the next cycle and that value plus one on the cycle after.
- R5: A fast counter read returns the counter as in R3; with `ts_off` low it is served at any privilege, with `ts_off` high only at privilege 0.
- R6: Index 0x0E is the test register: a write at privilege 0 stores `wr_lo` bit 3 and drives it on `l1_off`; a read returns that bit at `rd_lo` bit 3 and zero in every other bit of both halves, whatever was written there.
- R7: An index access at nonzero privilege, an index access to any index other than 0x10 and 0x0E, or a denied fast read raises `fault` for exactly the following cycle and leaves the counter sequence, the cache-inhibit bit and the read halves as if no access had been made.
- R8: When strobes coincide only one is served, write first, then index read, then fast read; the others have no effect.
- R9: Between served reads the read halves hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Index read strobe |
| wr_req | input | 1 | Index write strobe |
| ts_req | input | 1 | Fast counter read strobe |
| idx | input | 32 | Register index |
| wr_hi | input | 32 | Write data, upper half |
| wr_lo | input | 32 | Write data, lower half |
| cpl | input | 2 | Current privilege level |
| ts_off | input | 1 | Restricts fast reads to privilege 0 |
| rd_hi | output | 32 | Read data, upper half |
| rd_lo | output | 32 | Read data, lower half |
| fault | output | 1 | One-cycle denied-access pulse |
| l1_off | output | 1 | Cache-inhibit bit, disables L1 caches |

## Verification
The bench builds the unit with its default parameters: 32-bit halves, index 0x10 for the counter, 0x0E for the test register and the inhibit bit at position 3. With the full 64-bit width, a directed write near all ones brings the counter wrap and the carry from the lower into the upper half within a few cycles, which random loads alone would not reach. Random strobes, indices drawn mostly from the two live values, all four privilege levels and both settings of the disable control cover the fault and priority paths against a bench-side model.

// File: rtl/msr_unit.sv
module msr_unit #(
  parameter int              DW      = 32,
  parameter int              IW      = 32,
  parameter logic [IW-1:0]   TSC_IDX = 'h10,
  parameter logic [IW-1:0]   TST_IDX = 'h0E,
  parameter int              CI_POS  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic          ts_req,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wr_hi,
  input  logic [DW-1:0] wr_lo,
  input  logic [1:0]    cpl,
  input  logic          ts_off,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo,
  output logic          fault,
  output logic          l1_off
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] tsc;
  logic [CW-1:0] rdat;
  logic          ci_q;

  wire priv    = (cpl == 2'd0);
  wire hit_tsc = (idx == TSC_IDX);
  wire hit_tst = (idx == TST_IDX);
  wire msr_ok  = priv & (hit_tsc | hit_tst);
  wire ts_ok   = ~ts_off | priv;

  wire do_wr = wr_req;
  wire do_rd = rd_req & ~wr_req;
  wire do_ts = ts_req & ~rd_req & ~wr_req;

  wire wr_tsc = do_wr & msr_ok & hit_tsc;
  wire wr_tst = do_wr & msr_ok & hit_tst;
  wire rd_cnt = (do_rd & msr_ok & hit_tsc) | (do_ts & ts_ok);
  wire rd_tst = do_rd & msr_ok & hit_tst;
  wire bad    = ((do_wr | do_rd) & ~msr_ok) | (do_ts & ~ts_ok);

  wire [CW-1:0] tst_view = CW'(ci_q) << CI_POS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsc   <= '0;
      rdat  <= '0;
      ci_q  <= 1'b0;
      fault <= 1'b0;
    end else begin
      tsc   <= wr_tsc ? {wr_hi, wr_lo} : tsc + CW'(1);
      fault <= bad;
      if (wr_tst) ci_q <= wr_lo[CI_POS];
      if (rd_cnt)      rdat <= tsc;
      else if (rd_tst) rdat <= tst_view;
    end
  end

  assign rd_hi  = rdat[CW-1:DW];
  assign rd_lo  = rdat[DW-1:0];
  assign l1_off = ci_q;

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && cpl == 2'd0 && idx == TSC_IDX) |=> tsc == $past(tsc) + CW'(1));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && cpl == 2'd0 && idx == TSC_IDX) |=> tsc == $past({wr_hi, wr_lo}));

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_req && !rd_req && !wr_req && ts_off && cpl != 2'd0) |=> fault && $stable(rdat));

  assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req && cpl == 2'd0 && idx == TST_IDX) |=> (rdat & ~(CW'(1) << CI_POS)) == '0);

  assert_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req || wr_req) && cpl != 2'd0) |=> fault && $stable(l1_off) && $stable(rdat));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req || wr_req || ts_req) |=> !fault && $stable(rdat));
endmodule

// File: tb/test_msr_unit.sv
`timescale 1ns/1ps
module test_msr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 0, wr_req = 0, ts_req = 0, ts_off = 0;
  logic [31:0] idx = 0, wr_hi = 0, wr_lo = 0;
  logic [1:0]  cpl = 0;
  logic [31:0] rd_hi, rd_lo;
  logic        fault, l1_off;

  msr_unit i_msr_unit (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .ts_req(ts_req),
    .idx(idx), .wr_hi(wr_hi), .wr_lo(wr_lo), .cpl(cpl), .ts_off(ts_off),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .fault(fault), .l1_off(l1_off)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [63:0] m_tsc = 0, m_rd = 0;
  logic        m_ci = 0, m_fault = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] view_tst(input logic ci);
    return {60'd0, ci, 3'd0};
  endfunction

  // one clock: drive at negedge, update model at the edge, check at next negedge
  task automatic step(input logic w, r, t, input logic [31:0] ix, hi, lo,
                      input logic [1:0] c, input logic d, input string tag);
    logic priv, known, ok, tsok, dw, dr, dt;
    string tg;
    wr_req = w; rd_req = r; ts_req = t; idx = ix; wr_hi = hi; wr_lo = lo; cpl = c; ts_off = d;
    priv = (c == 0); known = (ix == 32'h10) || (ix == 32'h0E);
    ok = priv && known; tsok = !d || priv;
    dw = w; dr = r && !w; dt = t && !r && !w;
    tg = tag;
    m_fault = ((dw || dr) && !ok) || (dt && !tsok);
    if (dr && ok && ix == 32'h10) begin m_rd = m_tsc; if (tg == "") tg = "R3"; end
    else if (dt && tsok)          begin m_rd = m_tsc; if (tg == "") tg = "R5"; end
    else if (dr && ok)            begin m_rd = view_tst(m_ci); if (tg == "") tg = "R6"; end
    if (dw && ok && ix == 32'h0E) m_ci = lo[3];
    if (dw && ok && ix == 32'h10) m_tsc = {hi, lo};
    else                          m_tsc = m_tsc + 64'd1;
    if (tg == "") tg = m_fault ? "R7" : "R9";
    @(negedge clk);
    chk({rd_hi, rd_lo} == m_rd, {tg, " read data"}, {rd_hi, rd_lo}, m_rd);
    chk(fault == m_fault, "R7 fault", {63'd0, fault}, {63'd0, m_fault});
    chk(l1_off == m_ci, "R6 cache inhibit", {63'd0, l1_off}, {63'd0, m_ci});
    wr_req = 0; rd_req = 0; ts_req = 0;
  endtask

  task automatic rd_cnt(input string tag);
    step(0, 1, 0, 32'h10, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] ix;
    repeat (3) @(negedge clk);
    chk({rd_hi, rd_lo} == 0, "R1 read data", {rd_hi, rd_lo}, 0);
    chk(!fault, "R1 fault", {63'd0, fault}, 0);
    chk(!l1_off, "R1 cache inhibit", {63'd0, l1_off}, 0);
    rst_n = 1;
    rd_cnt("R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
    rd_cnt("R2");
    // load near all ones, watch wrap and carry
    step(1, 0, 0, 32'h10, 32'hFFFFFFFF, 32'hFFFFFFFE, 0, 0, "R4");
    rd_cnt("R4");
    rd_cnt("R2");
    rd_cnt("R2");
    step(1, 0, 0, 32'h10, 32'h00000000, 32'hFFFFFFFF, 0, 0, "R4");
    rd_cnt("R2");
    // test register, reserved bits
    step(1, 0, 0, 32'h0E, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, "R6");
    step(0, 1, 0, 32'h0E, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 32'h0E, 32'hFFFFFFFF, 32'hFFFFFFF7, 0, 0, "R6");
    step(0, 1, 0, 32'h0E, 0, 0, 0, 0, "R6");
    // denied and unknown accesses
    step(1, 0, 0, 32'h10, 32'h12345678, 32'h9ABCDEF0, 3, 0, "R7");
    rd_cnt("R7");
    step(1, 0, 0, 32'h11, 32'h12345678, 32'h9ABCDEF0, 0, 0, "R7");
    step(1, 0, 0, 32'h0E, 0, 32'h8, 1, 0, "R7");
    step(0, 1, 0, 32'h0E, 0, 0, 2, 0, "R7");
    step(0, 1, 0, 32'h0E, 0, 0, 0, 0, "R7");
    // fast read gating
    step(0, 0, 1, 0, 0, 0, 3, 1, "R5");
    step(0, 0, 1, 0, 0, 0, 3, 0, "R5");
    step(0, 0, 1, 0, 0, 0, 0, 1, "R5");
    // priority
    step(1, 1, 1, 32'h10, 32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0, "R8");
    step(0, 1, 1, 32'h0E, 0, 0, 0, 0, "R8");
    rd_cnt("R8");
    // random traffic
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 3))
        0, 1: ix = 32'h10;
        2:    ix = 32'h0E;
        default: ix = $urandom();
      endcase
      step($urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           ix, $urandom(), $urandom(), 2'($urandom_range(0, 3)) & ($urandom_range(0, 1) ? 2'd3 : 2'd0),
           $urandom_range(0, 1) == 1, "");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule